// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Arbiter

This block sits beside a processor core's exception logic and decides when an asynchronous interrupt is handed to the core. It watches three sources. The first is an imprecise floating-point enabled-exception condition. The second is a level-held external interrupt line. The third is a one-shot decrementer underflow pulse. The block keeps a pending flag for each source that needs one. When a source is eligible, it issues a one-cycle delivery strobe together with a vector offset, a reason word for the saved machine status, and the identity of the source taken. The core saves state and redirects fetch; the block only arbitrates.

The floating-point condition is a level. It is present whenever either floating-point exception mode bit is set and the status summary flag is set, and it is never gated by the external-enable bit. The external and decrementer sources are gated by the external-enable bit. The external flag tracks its input line. The decrementer flag is sticky until it is taken. A finite-state machine with three states, `ST_IDLE`, `ST_ISSUE` and `ST_WAIT`, keeps at most one delivery outstanding. The transitions are:
- `ST_IDLE` → `ST_ISSUE` when a source is eligible (a *take*).
- `ST_ISSUE` → `ST_IDLE` when the acknowledge arrives in the strobe cycle.
- `ST_ISSUE` → `ST_WAIT` when the acknowledge does not arrive in the strobe cycle.
- `ST_WAIT` → `ST_IDLE` on acknowledge.
- `ST_WAIT` → `ST_WAIT` while the acknowledge is absent.

Top module: `irqarb_top`

## Requirements
- R1: After reset, `deliver_o` is 0, `src_o` is 0 (none), and no source is pending.
- R2: When the floating-point condition ((`fp_mode_i[0]` or `fp_mode_i[1]`) and `fp_fex_i`) is eligible, it wins over both other sources. Its delivery has `vec_o` = 0x700, `src_o` = 1, and `reason_o` with bits 20 (enabled exception) and 16 (subsequent instruction) set and all other bits clear.
- R3: The floating-point condition is delivered whatever the value of `msr_ee_i`.
- R4: External and decrementer sources are delivered only if `msr_ee_i` was 1 at the decision edge. A source held off by a clear enable is delivered once the enable is set again.
- R5: External beats decrementer. An external delivery has `vec_o` = 0x500, `src_o` = 2 and `reason_o` = 0.
- R6: The external pending flag follows the line one cycle late. A pulse that ends while the enable is clear leaves nothing to deliver.
- R7: A decrementer pulse sets a sticky flag. The flag is delivered exactly once, with `vec_o` = 0x900, `src_o` = 3 and `reason_o` = 0, and is cleared by that delivery. A new pulse in the same cycle keeps it set.
- R8: No new delivery is issued between a strobe and its acknowledge. The acknowledge may arrive in the strobe cycle or later.
- R9: `deliver_o` is high for exactly one cycle per delivery. `vec_o`, `reason_o` and `src_o` are zero whenever `deliver_o` is low.
- R10: After an external delivery, the external source is blocked until `msr_ee_i` has been seen low at least once, even if the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 1 | External interrupt line, level |
| dec_tick_i | input | 1 | Decrementer underflow pulse |
| msr_ee_i | input | 1 | External-enable bit of the machine state |
| fp_mode_i | input | 2 | Floating-point exception mode bits |
| fp_fex_i | input | 1 | Floating-point enabled-exception summary flag |
| ack_i | input | 1 | Core has accepted the delivery |
| deliver_o | output | 1 | One-cycle delivery strobe |
| vec_o | output | VEC_W (16) | Vector offset of the delivery |
| reason_o | output | RSN_W (32) | Reason bits for the saved status word |
| src_o | output | 2 | Source taken: 0 none, 1 floating point, 2 external, 3 decrementer |

## Verification
Several properties are checked by the assertions on every cycle:
- the strobe never lasts longer than one cycle;
- every delivery carries the vector and reason word that belong to its source;
- external and decrementer deliveries follow a decision edge at which the enable was set;
- external deliveries follow a line level that was high two cycles earlier.

Other behaviours only show up over sequences of events, so the bench's scenarios must demonstrate them. These are the ordering among simultaneous sources, the once-only decrementer, the re-blocking of a held external line until the enable toggles, the loss of a short external pulse, and the absence of a second strobe while an acknowledge is outstanding.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FP   = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } irq_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/irqarb_pending.sv
module irqarb_pending
    import irqarb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_irq_i,
    input  logic     dec_tick_i,
    input  logic     msr_ee_i,
    input  logic     take_i,
    input  irq_src_e take_src_i,
    output logic     ext_pend_o,
    output logic     dec_pend_o,
    output logic     ext_blk_o
);

    // External flag mirrors the line; decrementer flag is sticky until taken;
    // block flag stops a held line from re-firing until the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_pend_o <= 1'b0;
            dec_pend_o <= 1'b0;
            ext_blk_o  <= 1'b0;
        end else begin
            ext_pend_o <= ext_irq_i;

            if (dec_tick_i)
                dec_pend_o <= 1'b1;
            else if (take_i && take_src_i == SRC_DEC)
                dec_pend_o <= 1'b0;

            if (take_i && take_src_i == SRC_EXT)
                ext_blk_o <= 1'b1;
            else if (!msr_ee_i)
                ext_blk_o <= 1'b0;
        end
    end

endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
    import irqarb_pkg::*;
#(
    parameter int FP_MODES = 2
) (
    input  logic [FP_MODES-1:0] fp_mode_i,
    input  logic                fp_fex_i,
    input  logic                msr_ee_i,
    input  logic                ext_pend_i,
    input  logic                dec_pend_i,
    input  logic                ext_blk_i,
    output logic                req_o,
    output irq_src_e            pick_o
);

    logic fp_cond;
    logic ext_ok;
    logic dec_ok;

    assign fp_cond = (|fp_mode_i) & fp_fex_i;
    assign ext_ok  = msr_ee_i & ext_pend_i & ~ext_blk_i;
    assign dec_ok  = msr_ee_i & dec_pend_i;

    // Fixed priority: floating point, then external, then decrementer.
    always_comb begin
        if (fp_cond)
            pick_o = SRC_FP;
        else if (ext_ok)
            pick_o = SRC_EXT;
        else if (dec_ok)
            pick_o = SRC_DEC;
        else
            pick_o = SRC_NONE;
    end

    assign req_o = fp_cond | ext_ok | dec_ok;

endmodule

// File: rtl/irqarb_fsm.sv
module irqarb_fsm
    import irqarb_pkg::*;
#(
    parameter int VEC_W   = 16,
    parameter int RSN_W   = 32,
    parameter int VEC_FP  = 'h700,
    parameter int VEC_EXT = 'h500,
    parameter int VEC_DEC = 'h900,
    parameter int BIT_FEX = 20,
    parameter int BIT_SUB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  irq_src_e         pick_i,
    input  logic             ack_i,
    output logic             take_o,
    output logic             deliver_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [RSN_W-1:0] reason_o,
    output irq_src_e         src_o
);

    localparam logic [RSN_W-1:0] RSN_FP_VAL =
        (RSN_W'(1) << BIT_FEX) | (RSN_W'(1) << BIT_SUB);

    arb_state_e state_q, state_d;
    irq_src_e   lat_q;

    assign take_o = (state_q == ST_IDLE) && req_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ack_i ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (ack_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            if (take_o)
                lat_q <= pick_i;
        end
    end

    // Output process: payload is shown only during the strobe cycle.
    always_comb begin
        deliver_o = (state_q == ST_ISSUE);
        src_o     = SRC_NONE;
        vec_o     = '0;
        reason_o  = '0;
        if (deliver_o) begin
            src_o = lat_q;
            unique case (lat_q)
                SRC_FP: begin
                    vec_o    = VEC_W'(VEC_FP);
                    reason_o = RSN_FP_VAL;
                end
                SRC_EXT: vec_o = VEC_W'(VEC_EXT);
                SRC_DEC: vec_o = VEC_W'(VEC_DEC);
                default: vec_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
    import irqarb_pkg::*;
#(
    parameter int VEC_W    = 16,
    parameter int RSN_W    = 32,
    parameter int FP_MODES = 2,
    parameter int VEC_FP   = 'h700,
    parameter int VEC_EXT  = 'h500,
    parameter int VEC_DEC  = 'h900,
    parameter int BIT_FEX  = 20,
    parameter int BIT_SUB  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_irq_i,
    input  logic                dec_tick_i,
    input  logic                msr_ee_i,
    input  logic [FP_MODES-1:0] fp_mode_i,
    input  logic                fp_fex_i,
    input  logic                ack_i,
    output logic                deliver_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic [RSN_W-1:0]    reason_o,
    output logic [1:0]          src_o
);

    logic     ext_pend, dec_pend, ext_blk;
    logic     req, take;
    irq_src_e pick, src_e;

    irqarb_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_irq_i  (ext_irq_i),
        .dec_tick_i (dec_tick_i),
        .msr_ee_i   (msr_ee_i),
        .take_i     (take),
        .take_src_i (pick),
        .ext_pend_o (ext_pend),
        .dec_pend_o (dec_pend),
        .ext_blk_o  (ext_blk)
    );

    irqarb_select #(.FP_MODES(FP_MODES)) u_sel (
        .fp_mode_i  (fp_mode_i),
        .fp_fex_i   (fp_fex_i),
        .msr_ee_i   (msr_ee_i),
        .ext_pend_i (ext_pend),
        .dec_pend_i (dec_pend),
        .ext_blk_i  (ext_blk),
        .req_o      (req),
        .pick_o     (pick)
    );

    irqarb_fsm #(
        .VEC_W(VEC_W), .RSN_W(RSN_W), .VEC_FP(VEC_FP), .VEC_EXT(VEC_EXT),
        .VEC_DEC(VEC_DEC), .BIT_FEX(BIT_FEX), .BIT_SUB(BIT_SUB)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .pick_i    (pick),
        .ack_i     (ack_i),
        .take_o    (take),
        .deliver_o (deliver_o),
        .vec_o     (vec_o),
        .reason_o  (reason_o),
        .src_o     (src_e)
    );

    assign src_o = src_e;

endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
    parameter int VEC_W   = 16,
    parameter int RSN_W   = 32,
    parameter int VEC_FP  = 'h700,
    parameter int VEC_EXT = 'h500,
    parameter int VEC_DEC = 'h900,
    parameter int BIT_FEX = 20,
    parameter int BIT_SUB = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_irq_i,
    input logic             msr_ee_i,
    input logic             deliver_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [RSN_W-1:0] reason_o,
    input logic [1:0]       src_o
);

    localparam logic [RSN_W-1:0] FP_RSN =
        (RSN_W'(1) << BIT_FEX) | (RSN_W'(1) << BIT_SUB);

    // R9: strobe lasts one cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_o |=> !deliver_o);

    // R9: quiet payload outside strobe
    a_r9_quiet_payload: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver_o |-> (src_o == 2'd0 && vec_o == '0 && reason_o == '0));

    // R2: floating-point payload
    a_r2_fp_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && src_o == 2'd1) |->
            (vec_o == VEC_W'(VEC_FP) && reason_o == FP_RSN));

    // R5: external payload
    a_r5_ext_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && src_o == 2'd2) |->
            (vec_o == VEC_W'(VEC_EXT) && reason_o == '0));

    // R7: decrementer payload
    a_r7_dec_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && src_o == 2'd3) |->
            (vec_o == VEC_W'(VEC_DEC) && reason_o == '0));

    // R4: gated sources need the enable at the decision edge
    a_r4_gated_by_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && src_o[1]) |-> $past(msr_ee_i));

    // R6: external delivery traces back to a high line
    a_r6_ext_level: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o && src_o == 2'd2) |-> $past(ext_irq_i, 2));

endmodule

bind irqarb_top irqarb_chk #(
    .VEC_W(VEC_W), .RSN_W(RSN_W), .VEC_FP(VEC_FP), .VEC_EXT(VEC_EXT),
    .VEC_DEC(VEC_DEC), .BIT_FEX(BIT_FEX), .BIT_SUB(BIT_SUB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq_i (ext_irq_i),
    .msr_ee_i  (msr_ee_i),
    .deliver_o (deliver_o),
    .vec_o     (vec_o),
    .reason_o  (reason_o),
    .src_o     (src_o)
);

// File: tb/sim_irqarb_top.sv
module sim_irqarb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq = 1'b0, dec_tick = 1'b0, msr_ee = 1'b0;
    logic [1:0]  fp_mode = 2'b00;
    logic        fp_fex = 1'b0, ack = 1'b1;
    logic        deliver;
    logic [15:0] vec;
    logic [31:0] reason;
    logic [1:0]  src;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irqarb_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .dec_tick_i(dec_tick),
        .msr_ee_i(msr_ee), .fp_mode_i(fp_mode), .fp_fex_i(fp_fex), .ack_i(ack),
        .deliver_o(deliver), .vec_o(vec), .reason_o(reason), .src_o(src)
    );

    function automatic logic [15:0] exp_vec(input logic [1:0] s);
        case (s)
            2'd1: return 16'h0700;
            2'd2: return 16'h0500;
            2'd3: return 16'h0900;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_rsn(input logic [1:0] s);
        return (s == 2'd1) ? ((32'd1 << 20) | (32'd1 << 16)) : 32'd0;
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'd1: return "R2";
            2'd2: return "R5";
            2'd3: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the requirements, advanced at each rising edge.
    int         m_st;
    logic       m_ext, m_dec, m_blk;
    logic [1:0] m_src;
    logic       mf_fp, mf_eok, mf_dok, mf_pick;
    logic [1:0] mf_ch;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ext = 0; m_dec = 0; m_blk = 0; m_src = 0;
        end else begin
            mf_fp  = (|fp_mode) & fp_fex;
            mf_eok = msr_ee & m_ext & ~m_blk;
            mf_dok = msr_ee & m_dec;
            mf_ch  = mf_fp ? 2'd1 : mf_eok ? 2'd2 : mf_dok ? 2'd3 : 2'd0;
            mf_pick = (m_st == 0) && (mf_ch != 2'd0);
            m_ext = ext_irq;
            if (dec_tick) m_dec = 1'b1;
            else if (mf_pick && mf_ch == 2'd3) m_dec = 1'b0;
            if (mf_pick && mf_ch == 2'd2) m_blk = 1'b1;
            else if (!msr_ee) m_blk = 1'b0;
            if (mf_pick) m_src = mf_ch;
            case (m_st)
                0: if (mf_pick) m_st = 1;
                1: m_st = ack ? 0 : 2;
                default: if (ack) m_st = 0;
            endcase
        end
    end

    // Per-cycle comparison and delivery log, sampled on the falling edge.
    bit         cmp_on = 0;
    int         n_log = 0;
    int         n_vld = 0;
    logic [1:0] dlog [0:63];

    always @(negedge clk) begin
        if (deliver) begin
            dlog[n_log % 64] = src;
            n_log++;
            n_vld++;
        end
        if (cmp_on && rst_n) begin
            logic [1:0] es;
            es = (m_st == 1) ? m_src : 2'd0;
            check(deliver == (m_st == 1), "R8", deliver, (m_st == 1));
            check(src == es, tag_of(es), src, es);
            check(vec == exp_vec(es), tag_of(es), vec, exp_vec(es));
            check(reason == exp_rsn(es), tag_of(es), reason, exp_rsn(es));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        cyc(3);
        // R1: reset state
        check(deliver == 1'b0, "R1", deliver, 0);
        check(src == 2'd0, "R1", src, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        cyc(3);
        check(n_log == 0, "R1", n_log, 0);

        // R3: floating point delivered with the enable clear
        base = n_log;
        msr_ee = 0; fp_mode = 2'b01; fp_fex = 1; cyc(1);
        fp_mode = 2'b00; fp_fex = 0; cyc(6);
        check(n_log - base == 1, "R3", n_log - base, 1);
        check(dlog[base % 64] == 2'd1, "R3", dlog[base % 64], 1);

        // R2, R5, R7, R10: all three at once, then held external line
        base = n_log;
        ext_irq = 1; dec_tick = 1; cyc(1);
        dec_tick = 0; cyc(3);
        check(n_log == base, "R4", n_log - base, 0);
        msr_ee = 1; fp_mode = 2'b10; fp_fex = 1; cyc(1);
        fp_mode = 2'b00; fp_fex = 0; cyc(14);
        check(n_log - base == 3, "R10", n_log - base, 3);
        check(dlog[base % 64] == 2'd1, "R2", dlog[base % 64], 1);
        check(dlog[(base + 1) % 64] == 2'd2, "R5", dlog[(base + 1) % 64], 2);
        check(dlog[(base + 2) % 64] == 2'd3, "R7", dlog[(base + 2) % 64], 3);

        // R10: enable toggles low then high, held line delivered again
        base = n_log;
        msr_ee = 0; cyc(1);
        msr_ee = 1; cyc(6);
        check(n_log - base == 1, "R10", n_log - base, 1);
        check(dlog[base % 64] == 2'd2, "R10", dlog[base % 64], 2);

        // R6: short pulse while disabled is lost
        base = n_log;
        ext_irq = 0; msr_ee = 0; cyc(2);
        ext_irq = 1; cyc(2);
        ext_irq = 0; cyc(2);
        msr_ee = 1; cyc(6);
        check(n_log == base, "R6", n_log - base, 0);

        // R4: held off then released by the enable
        base = n_log;
        msr_ee = 0; ext_irq = 1; cyc(8);
        check(n_log == base, "R4", n_log - base, 0);
        msr_ee = 1; cyc(4);
        check(n_log - base == 1, "R4", n_log - base, 1);

        // R8, R9: no acknowledge, more sources arrive
        ext_irq = 0; ack = 0; msr_ee = 0; cyc(2);
        base = n_vld;
        dec_tick = 1; cyc(1);
        dec_tick = 0; msr_ee = 1; cyc(10);
        check(n_vld - base == 1, "R9", n_vld - base, 1);
        fp_mode = 2'b01; fp_fex = 1; cyc(4);
        check(n_vld - base == 1, "R8", n_vld - base, 1);
        fp_mode = 2'b00; fp_fex = 0; ack = 1; cyc(4);
        check(n_vld - base == 1, "R8", n_vld - base, 1);

        // R7: a second decrementer event is delivered exactly once
        base = n_log;
        dec_tick = 1; cyc(1);
        dec_tick = 0; cyc(8);
        check(n_log - base == 1, "R7", n_log - base, 1);

        // Constrained random mix, checked each cycle against the model
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 4000; i++) begin
            ext_irq  = ($urandom_range(0, 7) != 0) ? ext_irq : ~ext_irq;
            dec_tick = ($urandom_range(0, 15) == 0);
            msr_ee   = ($urandom_range(0, 9) != 0) ? msr_ee : ~msr_ee;
            fp_mode  = ($urandom_range(0, 19) == 0) ? 2'($urandom) : fp_mode;
            fp_fex   = ($urandom_range(0, 11) == 0) ? ~fp_fex : fp_fex;
            ack      = ($urandom_range(0, 2) != 0);
            cyc(1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule